// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI host that runs one complete flash-style command for each trigger. Software loads a command byte into its own register. It places the outgoing payload bytes in a shared byte buffer and sets a transmit length, a receive length and a chip-select index. It then writes the start bit. The engine pulls the selected chip-select line low and shifts out the command byte, followed by the payload. It then clocks in the requested number of response bytes. Those bytes land in the same buffer, directly behind the payload. A busy flag lets software poll for completion.

The shared buffer is reached in two ways. Each byte can be addressed directly in a window of the register space. There is also a streaming port that returns the byte under an internal pointer and steps that pointer by one. The engine uses the same pointer to fetch payload bytes and to store response bytes. For that reason, software clears the pointer before a command, usually in the same write that starts it. The serial interface runs in mode 0 with a clock derived from the system clock by a divider parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the command, control, transmit-length, receive-length and select registers (offsets 0x00..0x04) read 0, all chip-select outputs are high, and the serial clock and data out are low.
- R2: The serial clock idles low. Each bit lasts 2*CLK_DIV system cycles: a low half first, then a high half. Data out holds steady while the clock is high.
- R3: The first byte on data out is the command register (offset 0x00), MSB first. It is followed by transmit-length (offset 0x02) bytes taken from the buffer starting at the pointer, which is index 0 after a clear. The command byte is not counted in the transmit length.
- R4: Response bytes are sampled on rising serial-clock edges, MSB first. There are receive-length (offset 0x03) of them, and they are written to the buffer starting at index pointer + transmit length.
- R5: Writing 1 to bit 0 of the control register (offset 0x01) while idle starts a command. Busy (bit 7 of offset 0x01) and the chip select go active in the next cycle. Busy stays high for exactly 16*CLK_DIV*(1 + transmit length + receive length) cycles.
- R6: Only the chip-select line given by the select register (offset 0x04, low bits) goes low. It stays low for the whole command, and every other line stays high.
- R7: While busy, every register and buffer write is dropped. This includes a second start and a change of the command byte.
- R8: Writing 1 to bit 1 of the control register resets the pointer to 0. Reading the streaming port (offset 0x05) returns the buffer byte at the pointer and advances the pointer by one, so a later command without a clear sends from the advanced index.
- R9: The 70-byte buffer is read and written directly at offsets 0x40..0x85. Unused offsets, including those past the buffer end, read 0.
- R10: A command with both lengths 0 sends only the command byte and then returns to idle.
- R11: The start bit reads back as 0; while a command runs the control register reads 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only matters for the streaming port) |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
A corrupted pointer or phase state does not stay hidden. Within one bit time it shows on data out as a payload bit taken from the wrong buffer index, or as a command that ends early or late, which changes the chip-select and busy lengths. A bad byte or bit counter moves the serial clock edges or the busy fall by a whole bit or byte period. A misplaced response write appears only at the buffer window once the command is over, so each command is followed by readback of the bytes around the expected landing zone.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_OPCODE = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h01;
  localparam logic [7:0] OFS_TXN    = 8'h02;
  localparam logic [7:0] OFS_RXN    = 8'h03;
  localparam logic [7:0] OFS_CSEL   = 8'h04;
  localparam logic [7:0] OFS_PORT   = 8'h05;

  // control register bits
  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_BUSY_BIT = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OPC,
    PH_TX,
    PH_RX
  } phase_e;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int AW    = 8,
  parameter int SEL_W = 2,
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             busy,
  input  logic             ptr_step,
  output logic [7:0]       opcode,
  output logic [7:0]       tx_num,
  output logic [7:0]       rx_num,
  output logic [SEL_W-1:0] cs_idx,
  output logic [PTR_W-1:0] ptr,
  output logic             go
);
  logic [7:0]       opc_q, opc_d;
  logic [7:0]       txn_q, txn_d;
  logic [7:0]       rxn_q, rxn_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             wr_ok;
  logic             ctrl_wr;

  always_comb begin
    wr_ok   = bus_wr && !busy;
    ctrl_wr = wr_ok && (bus_addr == AW'(OFS_CTRL));
    opc_d   = opc_q;
    txn_d   = txn_q;
    rxn_d   = rxn_q;
    sel_d   = sel_q;
    ptr_d   = ptr_q;
    if (wr_ok && bus_addr == AW'(OFS_OPCODE)) opc_d = bus_wdata;
    if (wr_ok && bus_addr == AW'(OFS_TXN))    txn_d = bus_wdata;
    if (wr_ok && bus_addr == AW'(OFS_RXN))    rxn_d = bus_wdata;
    if (wr_ok && bus_addr == AW'(OFS_CSEL))   sel_d = bus_wdata[SEL_W-1:0];
    if (ctrl_wr && bus_wdata[CTRL_CLR_BIT]) begin
      ptr_d = '0;
    end else if (ptr_step || (bus_rd && !busy && bus_addr == AW'(OFS_PORT))) begin
      ptr_d = ptr_q + 1'b1;
    end
    go = ctrl_wr && bus_wdata[CTRL_GO_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
      txn_q <= '0;
      rxn_q <= '0;
      sel_q <= '0;
      ptr_q <= '0;
    end else begin
      opc_q <= opc_d;
      txn_q <= txn_d;
      rxn_q <= rxn_d;
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end

  assign opcode = opc_q;
  assign tx_num = txn_q;
  assign rx_num = rxn_q;
  assign cs_idx = sel_q;
  assign ptr    = ptr_q;
endmodule

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int DEPTH = 70,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  // bus side
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [7:0]       a_wdata,
  output logic [7:0]       a_rdata,
  // engine side, wins on a collision
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [7:0]       b_wdata,
  output logic [7:0]       b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (b_we && b_idx == IDX_W'(i)) begin
        mem[i] <= b_wdata;
      end else if (a_we && a_idx == IDX_W'(i)) begin
        mem[i] <= a_wdata;
      end
    end
  end

  always_comb begin
    a_rdata = '0;
    b_rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (a_idx == IDX_W'(i)) a_rdata = mem[i];
      if (b_idx == IDX_W'(i)) b_rdata = mem[i];
    end
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_byte,
  input  logic       run,
  input  logic [7:0] next_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_end,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;
  logic             half_end;

  assign half_end = run && (div_q == DIV_LAST);
  assign byte_end = half_end && sclk_q && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (start) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_sr  <= start_byte;
    end else if (half_end) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sr  <= {rx_sr[6:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          tx_sr <= next_byte;
        end else begin
          bit_q <= bit_q + 3'd1;
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end else if (run) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = run ? tx_sr[7] : 1'b0;
  assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_num,
  input  logic [7:0] rx_num,
  input  logic       byte_end,
  input  logic [7:0] buf_byte,
  output logic       active,
  output logic [7:0] next_byte,
  output logic       ptr_step,
  output logic       buf_we
);
  phase_e     phase_q, phase_d;
  logic [7:0] left_q, left_d;

  always_comb begin
    phase_d   = phase_q;
    left_d    = left_q;
    next_byte = '0;
    ptr_step  = 1'b0;
    buf_we    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (go) phase_d = PH_OPC;
      end
      PH_OPC: begin
        if (byte_end) begin
          if (tx_num != 8'd0) begin
            phase_d   = PH_TX;
            left_d    = tx_num;
            next_byte = buf_byte;
            ptr_step  = 1'b1;
          end else if (rx_num != 8'd0) begin
            phase_d = PH_RX;
            left_d  = rx_num;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_TX: begin
        if (byte_end) begin
          if (left_q != 8'd1) begin
            left_d    = left_q - 8'd1;
            next_byte = buf_byte;
            ptr_step  = 1'b1;
          end else if (rx_num != 8'd0) begin
            phase_d = PH_RX;
            left_d  = rx_num;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_RX: begin
        if (byte_end) begin
          buf_we   = 1'b1;
          ptr_step = 1'b1;
          if (left_q != 8'd1) left_d = left_q - 8'd1;
          else                phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
    end else begin
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  assign active = (phase_q != PH_IDLE);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NCS       = 4,
  parameter int BUF_DEPTH = 70,
  parameter int BUF_BASE  = 64,
  parameter int CLK_DIV   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n
);
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int PTR_W = 8;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             eng_busy;
  logic             eng_go;
  logic             ptr_step;
  logic [7:0]       reg_opcode, reg_txn, reg_rxn;
  logic [SEL_W-1:0] reg_sel;
  logic [PTR_W-1:0] reg_ptr;
  logic             buf_hit;
  logic [PTR_W-1:0] buf_bus_idx;
  logic [7:0]       buf_bus_rdata;
  logic [7:0]       buf_ptr_rdata;
  logic             eng_buf_we;
  logic [7:0]       next_byte;
  logic             byte_end;
  logic [7:0]       rx_byte;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign buf_hit     = (int'(bus_addr) >= BUF_BASE) && (int'(bus_addr) < BUF_BASE + BUF_DEPTH);
  assign buf_bus_idx = PTR_W'(bus_addr - AW'(BUF_BASE));

  spi_cmd_regs #(.AW(AW), .SEL_W(SEL_W), .PTR_W(PTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (eng_busy),
    .ptr_step  (ptr_step),
    .opcode    (reg_opcode),
    .tx_num    (reg_txn),
    .rx_num    (reg_rxn),
    .cs_idx    (reg_sel),
    .ptr       (reg_ptr),
    .go        (eng_go)
  );

  spi_cmd_buffer #(.DEPTH(BUF_DEPTH), .IDX_W(PTR_W)) u_buf (
    .clk     (clk),
    .a_we    (bus_wr && buf_hit && !eng_busy),
    .a_idx   (buf_bus_idx),
    .a_wdata (bus_wdata),
    .a_rdata (buf_bus_rdata),
    .b_we    (eng_buf_we),
    .b_idx   (reg_ptr),
    .b_wdata (rx_byte),
    .b_rdata (buf_ptr_rdata)
  );

  spi_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go        (eng_go),
    .tx_num    (reg_txn),
    .rx_num    (reg_rxn),
    .byte_end  (byte_end),
    .buf_byte  (buf_ptr_rdata),
    .active    (eng_busy),
    .next_byte (next_byte),
    .ptr_step  (ptr_step),
    .buf_we    (eng_buf_we)
  );

  spi_cmd_shifter #(.DIV(CLK_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (eng_go),
    .start_byte (reg_opcode),
    .run        (eng_busy),
    .next_byte  (next_byte),
    .miso       (spi_miso),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .byte_end   (byte_end),
    .rx_byte    (rx_byte)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign spi_cs_n[g] = !(eng_busy && reg_sel == SEL_W'(g));
  end

  always_comb begin
    bus_rdata = '0;
    if (buf_hit) begin
      bus_rdata = buf_bus_rdata;
    end else begin
      case (bus_addr)
        AW'(OFS_OPCODE): bus_rdata = reg_opcode;
        AW'(OFS_CTRL):   bus_rdata = {eng_busy, 7'd0};
        AW'(OFS_TXN):    bus_rdata = reg_txn;
        AW'(OFS_RXN):    bus_rdata = reg_rxn;
        AW'(OFS_CSEL):   bus_rdata = 8'(reg_sel);
        AW'(OFS_PORT):   bus_rdata = buf_ptr_rdata;
        default:         bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker
  import spi_cmd_pkg::*;
#(
  parameter int AW  = 8,
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [7:0]     bus_wdata,
  input logic           busy,
  input logic [7:0]     opcode,
  input logic [7:0]     tx_num,
  input logic [7:0]     ptr,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n
);
  logic ctrl_wr_idle;
  assign ctrl_wr_idle = bus_wr && !busy && bus_addr == AW'(OFS_CTRL);

  assert_one_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  assert_cs_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (spi_cs_n != '1));

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_idle && bus_wdata[CTRL_GO_BIT]) |=> busy);

  assert_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> ($stable(opcode) && $stable(tx_num)));

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_idle && bus_wdata[CTRL_CLR_BIT]) |=> (ptr == 8'd0));
endmodule

bind spi_cmd_engine spi_cmd_checker #(.AW(AW), .NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (eng_busy),
  .opcode    (reg_opcode),
  .tx_num    (reg_txn),
  .ptr       (reg_ptr),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int NCS   = 4;
  localparam int DEPTH = 70;
  localparam int BASE  = 64;

  logic           clk;
  logic           rst_n;
  logic           bus_wr;
  logic           bus_rd;
  logic [7:0]     bus_addr;
  logic [7:0]     bus_wdata;
  logic [7:0]     bus_rdata;
  logic           spi_sclk;
  logic           spi_mosi;
  logic           spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int n_chk;
  int n_bad;

  spi_cmd_engine #(.AW(8), .NCS(NCS), .BUF_DEPTH(DEPTH), .BUF_BASE(BASE), .CLK_DIV(DIV)) i_spi_cmd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_opc, m_txn, m_rxn, m_sel;
  int         m_ptr;
  bit         m_busy;
  int         m_t, m_total, m_txa;
  logic [7:0] m_q[$];
  logic [7:0] resp [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_opc = 0; m_txn = 0; m_rxn = 0; m_sel = 0; m_ptr = 0;
      m_busy = 0; m_t = 0; m_total = 0; m_txa = 0;
    end else if (m_busy) begin
      m_t = m_t + 1;
      if (m_t == m_total) m_busy = 0;
    end else if (bus_wr) begin
      if (bus_addr >= 8'(BASE) && int'(bus_addr) < BASE + DEPTH) m_mem[int'(bus_addr) - BASE] = bus_wdata;
      case (bus_addr)
        8'h00: m_opc = bus_wdata;
        8'h02: m_txn = bus_wdata;
        8'h03: m_rxn = bus_wdata;
        8'h04: m_sel = {6'd0, bus_wdata[1:0]};
        8'h01: begin
          if (bus_wdata[1]) m_ptr = 0;
          if (bus_wdata[0]) begin
            m_q.delete();
            m_q.push_back(m_opc);
            for (int j = 0; j < int'(m_txn); j++)
              m_q.push_back((m_ptr + j < DEPTH) ? m_mem[m_ptr + j] : 8'h00);
            for (int j = 0; j < int'(m_rxn); j++) m_q.push_back(8'h00);
            for (int j = 0; j < int'(m_rxn); j++)
              if (m_ptr + int'(m_txn) + j < DEPTH) m_mem[m_ptr + int'(m_txn) + j] = resp[j];
            m_ptr   = (m_ptr + int'(m_txn) + int'(m_rxn)) % 256;
            m_txa   = int'(m_txn);
            m_total = 16 * DIV * (1 + int'(m_txn) + int'(m_rxn));
            m_t     = 0;
            m_busy  = 1;
          end
        end
        default: ;
      endcase
    end else if (bus_rd && bus_addr == 8'h05) begin
      m_ptr = (m_ptr + 1) % 256;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and serial slave drive
  logic           e_sclk, e_mosi;
  logic [NCS-1:0] e_cs;
  logic [7:0]     cur;
  int             bi, byi;

  always @(negedge clk) begin
    spi_miso = 1'b0;
    if (m_busy) begin
      e_sclk = (m_t % (2*DIV)) >= DIV;
      bi     = m_t / (2*DIV);
      byi    = bi / 8;
      cur    = m_q[byi];
      e_mosi = cur[7 - (bi % 8)];
      e_cs   = ~(NCS'(1) << m_sel);
      if (byi > m_txa) begin
        cur      = resp[byi - 1 - m_txa];
        spi_miso = cur[7 - (bi % 8)];
      end
    end else begin
      e_sclk = 1'b0;
      e_mosi = 1'b0;
      e_cs   = '1;
    end
    if (rst_n) begin
      chk(spi_sclk == e_sclk, "R2 sclk", spi_sclk, e_sclk);
      chk(spi_mosi == e_mosi, "R3 mosi", spi_mosi, e_mosi);
      chk(spi_cs_n == e_cs,   "R6 cs_n", spi_cs_n, e_cs);
      chk((spi_cs_n != '1) == m_busy, "R5 busy window", spi_cs_n, e_cs);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic port_chk(input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_addr = 8'h05; bus_rd = 1'b1;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (m_busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic setup_cmd(input logic [7:0] opc, input logic [7:0] tx,
                           input logic [7:0] rx, input logic [7:0] sel);
    wr(8'h00, opc);
    wr(8'h02, tx);
    wr(8'h03, rx);
    wr(8'h04, sel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; spi_miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 5; a++) rd_chk(8'(a), 8'h00, "R1 reg reset");
    chk(spi_cs_n == '1, "R1 cs idle", spi_cs_n, 4'hF);

    // R9 buffer fill and direct access
    for (int i = 0; i < DEPTH; i++) wr(8'(BASE + i), 8'(i * 7 + 3));
    rd_chk(8'(BASE), 8'h03, "R9 buf first");
    rd_chk(8'(BASE + DEPTH - 1), 8'((DEPTH - 1) * 7 + 3), "R9 buf last");
    rd_chk(8'(BASE + DEPTH), 8'h00, "R9 past end");
    rd_chk(8'h10, 8'h00, "R9 unused");

    // A: receive only, select 2 (R4, R6)
    resp[0] = 8'hC2; resp[1] = 8'h20; resp[2] = 8'h18;
    setup_cmd(8'h9F, 8'd0, 8'd3, 8'd2);
    wr(8'h01, 8'h03);
    rd_chk(8'h01, 8'h80, "R11 ctrl busy");
    wait_idle();
    for (int i = 0; i < 3; i++) rd_chk(8'(BASE + i), resp[i], "R4 rx landing A");
    rd_chk(8'(BASE + 3), m_mem[3], "R4 neighbour A");
    rd_chk(8'h01, 8'h00, "R11 ctrl idle");

    // B: transmit 4 then receive 2, select 1; writes while busy (R3, R4, R7)
    resp[0] = 8'h5A; resp[1] = 8'hA5;
    setup_cmd(8'h0B, 8'd4, 8'd2, 8'd1);
    wr(8'h01, 8'h03);
    wr(8'h00, 8'h55);
    wr(8'h01, 8'h03);
    wr(8'h02, 8'h09);
    wait_idle();
    rd_chk(8'h00, 8'h0B, "R7 opcode kept");
    rd_chk(8'h02, 8'h04, "R7 txn kept");
    rd_chk(8'(BASE + 4), 8'h5A, "R4 rx landing B0");
    rd_chk(8'(BASE + 5), 8'hA5, "R4 rx landing B1");
    rd_chk(8'(BASE + 6), m_mem[6], "R4 neighbour B");
    rd_chk(8'(BASE + 0), m_mem[0], "R3 tx source kept");

    // C: zero lengths, select 0 (R10, R5)
    setup_cmd(8'h06, 8'd0, 8'd0, 8'd0);
    wr(8'h01, 8'h01);
    cnt = 0;
    while (spi_cs_n != '1 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 16 * DIV, "R10 opcode-only length", cnt, 16 * DIV);
    wait_idle();

    // D: pointer clear and streaming port, then command without clear (R8)
    resp[0] = 8'h3E;
    wr(8'h01, 8'h02);
    port_chk(m_mem[0], "R8 port byte 0");
    port_chk(m_mem[1], "R8 port byte 1");
    setup_cmd(8'h3C, 8'd2, 8'd1, 8'd3);
    wr(8'h01, 8'h01);
    wait_idle();
    rd_chk(8'(BASE + 4), 8'h3E, "R8 rx after advanced pointer");
    port_chk(m_mem[5], "R8 pointer after command");

    // E: longer burst, transmit 5 receive 4, select 3 (R3, R4)
    for (int i = 0; i < 4; i++) resp[i] = 8'(8'h81 + i * 17);
    setup_cmd(8'hE7, 8'd5, 8'd4, 8'd3);
    wr(8'h01, 8'h03);
    wait_idle();
    for (int i = 0; i < 4; i++) rd_chk(8'(BASE + 5 + i), resp[i], "R4 rx landing E");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule